// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

A memory-mapped general-purpose I/O port of `PIN_COUNT` pins (6 to 16), reached through a plain 32-bit register bus. The bus write is taken on the rising clock edge when `bus_we` is high. The read data is a combinational function of `bus_addr`, which is a byte address decoded on bits [5:2]. Software sets each pin's direction and output level. It reads the synchronised level of every pin, whatever the direction of the pin.

Each pin has its own trigger detector. The detector runs on the pin after a two-flop synchroniser and recognises one of five edge or level conditions. Detected events latch into a status register. Software clears status bits by writing ones to a separate clear address. A mask with separate set and clear addresses, together with a per-pin enable, decides which latched bits reach the single interrupt output.

A two-state soft-reset controller handles the reset register. Its states are `SR_RUN` (normal operation) and `SR_HOLD` (port registers held at zero). Writing 1 to the reset register takes the transition `SR_RUN -> SR_HOLD`. Writing 0 takes the transition `SR_HOLD -> SR_RUN`. Every other write leaves the state unchanged.

Register map (byte offsets):

| Offset | Register |
|--------|----------|
| 0x00 | output data |
| 0x04 | input levels (read only) |
| 0x08 | direction, 1 = output |
| 0x0C | interrupt enable |
| 0x10 | mask set (write) / mask (read) |
| 0x14 | mask clear (write) / mask (read) |
| 0x18 | status (read) |
| 0x1C | status clear (write) |
| 0x20 | mode, pins 0-7 |
| 0x24 | mode, pins 8-15 |
| 0x28 | soft reset, bit 0 |

Top module: `gpio_irq_port`

## Requirements
- R1: After `rst`, every register reads zero, except the input levels register. `pin_oe` is zero (all pins are inputs), every mode is falling edge, and `irq_out` is low.
- R2: `pin_out` equals the output data register and `pin_oe` equals the direction register. Direction bits at or above `PIN_COUNT` are ignored and read as zero.
- R3: The input levels register (0x04) reports each pin level two clock edges after the pin changes, regardless of direction.
- R4: Each pin's mode field sits at bits 4*k+2..4*k. For pins 0-7, k is the pin index and the field is in register 0x20. For pins 8-15, k is the pin index minus 8 and the field is in register 0x24. Bit 4*k+3 and the fields of absent pins read as zero.
- R5: The mode codes are 0 = falling edge, 1 = rising edge, 2 = low level, 3 = high level, 4 = both edges. Codes 5 to 7 never trigger. In the edge modes, a status bit sets once per qualifying edge, on the third clock edge after the pin change.
- R6: In the level modes, the status bit is set on every cycle the level is active, so it reasserts after a clear while the level persists.
- R7: Writing a 1 to a bit of 0x1C clears that status bit, and 0 bits have no effect. A detection in the same cycle as a clear wins, and the bit stays set.
- R8: Writing 1 bits to 0x10 masks those pins and writing 1 bits to 0x14 unmasks them. Zero bits leave the mask unchanged. Both addresses read the mask.
- R9: The status bit of a pin whose enable bit is 0 does not set.
- R10: `irq_out` is the OR of status bits that are enabled and not masked. The status register reads the latched bits whatever the mask.
- R11: After a 1 then a 0 is written to 0x28, all port registers are zero. While the controller is in `SR_HOLD`, the reset register reads 1 and writes to other registers have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 6 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | PIN_COUNT | Asynchronous pin levels |
| pin_out | output | PIN_COUNT | Output data towards the pads |
| pin_oe | output | PIN_COUNT | Output enable per pin |
| irq_out | output | 1 | Interrupt request |

## Verification
The detectors are driven in three ways. Rising and falling steps on pins held in different modes show whether each edge code reacts only to its own polarity, and whether an unused code stays silent. Levels held across a clear show the difference between latched-once edge behaviour and level reassertion. A latched edge bit is toggled through mask set, mask clear and a zero-valued clear, which separates the raw status from the gated interrupt. Register writes at unused bit positions, the disabled pin case and a soft reset during held writes confirm the ignored and reset behaviour at the read port.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
    typedef enum logic [2:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_mode_e;

    typedef enum logic [3:0] {
        SEL_DOUT  = 4'd0,
        SEL_DIN   = 4'd1,
        SEL_DIR   = 4'd2,
        SEL_IEN   = 4'd3,
        SEL_MSET  = 4'd4,
        SEL_MCLR  = 4'd5,
        SEL_STAT  = 4'd6,
        SEL_SCLR  = 4'd7,
        SEL_MODE0 = 4'd8,
        SEL_MODE1 = 4'd9,
        SEL_SRST  = 4'd10
    } reg_sel_e;

    typedef enum logic {
        SR_RUN  = 1'b0,
        SR_HOLD = 1'b1
    } srst_state_e;

    localparam int MODE_W     = 3;
    localparam int FIELD_W    = 4;
    localparam int PINS_PER_R = 8;
endpackage

// File: rtl/gpio_pin_sync.sv
`timescale 1ns/1ps
module gpio_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
`timescale 1ns/1ps
module gpio_trig_detect
    import gpio_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_async,
    input  logic [MODE_W-1:0] mode,
    output logic              level,
    output logic              hit
);
    logic prev_q;
    logic rise_ev;
    logic fall_ev;

    gpio_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .d_async(pin_async),
        .q      (level)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rise_ev = level & ~prev_q;
    assign fall_ev = ~level & prev_q;

    always_comb begin
        case (mode)
            TRIG_FALL: hit = fall_ev;
            TRIG_RISE: hit = rise_ev;
            TRIG_LOW:  hit = ~level;
            TRIG_HIGH: hit = level;
            TRIG_BOTH: hit = rise_ev | fall_ev;
            default:   hit = 1'b0;
        endcase
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_ev |=> !rise_ev); // R5
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [5:0]           bus_addr,
    input  logic                 bus_we,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe,
    output logic                 irq_out
);
    localparam int P = PIN_COUNT;

    srst_state_e state_q, state_d;
    logic        held;

    logic [P-1:0]      dout_q, dir_q, ien_q, mask_q, stat_q;
    logic [MODE_W-1:0] mode_q [P];
    logic [P-1:0]      lvl, hit_raw, wbits;
    logic [3:0]        sel;
    logic              wr_dout, wr_dir, wr_ien, wr_mset, wr_mclr, wr_sclr;
    logic              wr_mode0, wr_mode1, wr_srst;
    logic [31:0]       mode0_rd, mode1_rd;

    assign sel   = bus_addr[5:2];
    assign wbits = bus_wdata[P-1:0];

    assign wr_dout  = bus_we && (sel == SEL_DOUT);
    assign wr_dir   = bus_we && (sel == SEL_DIR);
    assign wr_ien   = bus_we && (sel == SEL_IEN);
    assign wr_mset  = bus_we && (sel == SEL_MSET);
    assign wr_mclr  = bus_we && (sel == SEL_MCLR);
    assign wr_sclr  = bus_we && (sel == SEL_SCLR);
    assign wr_mode0 = bus_we && (sel == SEL_MODE0);
    assign wr_mode1 = bus_we && (sel == SEL_MODE1);
    assign wr_srst  = bus_we && (sel == SEL_SRST);

    // Per-pin synchroniser and trigger detector
    for (genvar g = 0; g < P; g++) begin : g_pin
        gpio_trig_detect #(.SYNC_STAGES(SYNC_STAGES)) det_i (
            .clk      (clk),
            .rst      (rst),
            .pin_async(pin_in[g]),
            .mode     (mode_q[g]),
            .level    (lvl[g]),
            .hit      (hit_raw[g])
        );
    end

    // Soft-reset controller: state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= SR_RUN;
        else     state_q <= state_d;
    end

    // Soft-reset controller: next state and output
    always_comb begin
        state_d = state_q;
        held    = 1'b0;
        unique case (state_q)
            SR_RUN: begin
                if (wr_srst && bus_wdata[0]) state_d = SR_HOLD;
            end
            SR_HOLD: begin
                held = 1'b1;
                if (wr_srst && !bus_wdata[0]) state_d = SR_RUN;
            end
        endcase
    end

    // Port registers
    always_ff @(posedge clk) begin
        if (rst || held) begin
            dout_q <= '0;
            dir_q  <= '0;
            ien_q  <= '0;
            mask_q <= '0;
            stat_q <= '0;
            for (int i = 0; i < P; i++) mode_q[i] <= '0;
        end else begin
            if (wr_dout) dout_q <= wbits;
            if (wr_dir)  dir_q  <= wbits;
            if (wr_ien)  ien_q  <= wbits;
            if (wr_mset)      mask_q <= mask_q | wbits;
            else if (wr_mclr) mask_q <= mask_q & ~wbits;
            stat_q <= (stat_q & ~(wr_sclr ? wbits : '0)) | (hit_raw & ien_q);
            for (int i = 0; i < P; i++) begin
                if ((i < PINS_PER_R && wr_mode0) || (i >= PINS_PER_R && wr_mode1))
                    mode_q[i] <= bus_wdata[FIELD_W*(i % PINS_PER_R) +: MODE_W];
            end
        end
    end

    // Mode register read images
    always_comb begin
        mode0_rd = '0;
        mode1_rd = '0;
        for (int i = 0; i < P; i++) begin
            if (i < PINS_PER_R) mode0_rd[FIELD_W*i +: MODE_W] = mode_q[i];
            else                mode1_rd[FIELD_W*(i-PINS_PER_R) +: MODE_W] = mode_q[i];
        end
    end

    // Read mux
    always_comb begin
        case (sel)
            SEL_DOUT:  bus_rdata = 32'(dout_q);
            SEL_DIN:   bus_rdata = 32'(lvl);
            SEL_DIR:   bus_rdata = 32'(dir_q);
            SEL_IEN:   bus_rdata = 32'(ien_q);
            SEL_MSET,
            SEL_MCLR:  bus_rdata = 32'(mask_q);
            SEL_STAT:  bus_rdata = 32'(stat_q);
            SEL_MODE0: bus_rdata = mode0_rd;
            SEL_MODE1: bus_rdata = mode1_rd;
            SEL_SRST:  bus_rdata = {31'd0, state_q == SR_HOLD};
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;
    assign irq_out = |(stat_q & ien_q & ~mask_q);

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!held && wr_sclr) |=> ((stat_q & $past(wbits & ~(hit_raw & ien_q))) == '0)); // R7
    AST_MASK_SETS: assert property (@(posedge clk) disable iff (rst)
        (!held && wr_mset) |=> ((mask_q & $past(wbits)) == $past(wbits))); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(ien_q)) == '0)); // R9
    AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq_out); // R10
    AST_HOLD_ZEROES: assert property (@(posedge clk) disable iff (rst)
        (state_q == SR_HOLD && $past(state_q) == SR_HOLD) |->
        (dout_q == '0 && dir_q == '0 && ien_q == '0 && mask_q == '0 && stat_q == '0)); // R11
endmodule

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;
    localparam int P = 12;

    localparam logic [5:0] A_DOUT = 6'h00, A_DIN = 6'h04, A_DIR = 6'h08, A_IEN = 6'h0C,
                           A_MSET = 6'h10, A_MCLR = 6'h14, A_STAT = 6'h18, A_SCLR = 6'h1C,
                           A_MODE0 = 6'h20, A_MODE1 = 6'h24, A_SRST = 6'h28;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [5:0]   bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [P-1:0] pin_in = '0;
    logic [P-1:0] pin_out, pin_oe;
    logic         irq_out;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_port #(.PIN_COUNT(P)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        rdchk("R1 dout", A_DOUT, 0);
        rdchk("R1 dir", A_DIR, 0);
        rdchk("R1 ien", A_IEN, 0);
        rdchk("R1 mask", A_MSET, 0);
        rdchk("R1 stat", A_STAT, 0);
        rdchk("R1 mode0", A_MODE0, 0);
        rdchk("R1 mode1", A_MODE1, 0);
        rdchk("R1 srst", A_SRST, 0);
        chk("R1 oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq_out), 0);
    endtask

    task automatic t_output;
        wr(A_DIR, 32'hFFFF_FFFF);
        rdchk("R2 dir upper bits", A_DIR, 32'h0000_0FFF);
        chk("R2 oe", 32'(pin_oe), 32'hFFF);
        wr(A_DOUT, 32'h0000_0A5A);
        chk("R2 pin_out", 32'(pin_out), 32'hA5A);
    endtask

    task automatic t_input;
        @(negedge clk);
        pin_in = 12'h3C3;
        @(negedge clk);
        rdchk("R3 din one edge", A_DIN, 0);
        @(negedge clk);
        rdchk("R3 din two edges", A_DIN, 32'h3C3);
        wr(A_DIR, 0);
        @(negedge clk);
        pin_in = '0;
        wait_clk(3);
        rdchk("R3 din input dir", A_DIN, 0);
    endtask

    task automatic t_modes;
        wr(A_MODE0, 32'hFFFF_FFFF);
        rdchk("R4 mode0 fields", A_MODE0, 32'h7777_7777);
        wr(A_MODE1, 32'hFFFF_FFFF);
        rdchk("R4 mode1 fields", A_MODE1, 32'h0000_7777);
        wr(A_MODE0, 0);
        wr(A_MODE1, 0);
    endtask

    task automatic t_edge;
        // pin0 rise, pin1 fall, pin2 both, pin7 code 5
        wr(A_MODE0, 32'h5000_0401);
        wr(A_IEN, 32'h87);
        @(negedge clk);
        pin_in = 12'h087;
        wait_clk(2);
        rdchk("R5 status not yet", A_STAT, 0);
        @(negedge clk);
        rdchk("R5 rising edges", A_STAT, 32'h5);
        chk("R10 irq on edge", 32'(irq_out), 1);
        wr(A_SCLR, 32'h5);
        wait_clk(2);
        rdchk("R5 edge once", A_STAT, 0);
        @(negedge clk);
        pin_in = '0;
        wait_clk(3);
        rdchk("R5 falling edges", A_STAT, 32'h6);
        wr(A_SCLR, 32'hFFF);
        wr(A_IEN, 0);
        rdchk("R7 clear all", A_STAT, 0);
    endtask

    task automatic t_level;
        // pin3 high level, pin4 low level
        wr(A_MODE0, 32'h0002_3000);
        wr(A_IEN, 32'h18);
        wait_clk(1);
        rdchk("R6 low level", A_STAT, 32'h10);
        wr(A_SCLR, 32'h10);
        rdchk("R6 R7 reassert", A_STAT, 32'h10);
        @(negedge clk);
        pin_in = 12'h008;
        wait_clk(3);
        rdchk("R6 high level", A_STAT, 32'h18);
        @(negedge clk);
        pin_in = 12'h018;
        wait_clk(3);
        wr(A_SCLR, 32'h18);
        rdchk("R6 only active stays", A_STAT, 32'h08);
        @(negedge clk);
        pin_in = 12'h010;
        wait_clk(3);
        wr(A_SCLR, 32'h08);
        rdchk("R6 cleared when idle", A_STAT, 0);
        wr(A_IEN, 0);
        @(negedge clk);
        pin_in = '0;
        wait_clk(3);
    endtask

    task automatic t_mask;
        wr(A_SCLR, 32'hFFF);
        wr(A_MODE0, 32'h0010_0000);
        wr(A_IEN, 32'h20);
        @(negedge clk);
        pin_in = 12'h020;
        wait_clk(3);
        rdchk("R5 pin5 rise", A_STAT, 32'h20);
        chk("R10 irq set", 32'(irq_out), 1);
        wr(A_SCLR, 0);
        rdchk("R7 zero clear", A_STAT, 32'h20);
        wr(A_MSET, 32'h20);
        chk("R10 irq masked", 32'(irq_out), 0);
        rdchk("R10 raw status", A_STAT, 32'h20);
        rdchk("R8 mask at set addr", A_MSET, 32'h20);
        rdchk("R8 mask at clear addr", A_MCLR, 32'h20);
        wr(A_MSET, 0);
        rdchk("R8 zero set", A_MSET, 32'h20);
        wr(A_MCLR, 0);
        rdchk("R8 zero clear", A_MSET, 32'h20);
        wr(A_MCLR, 32'h20);
        rdchk("R8 unmask", A_MSET, 0);
        chk("R10 irq unmasked", 32'(irq_out), 1);
        wr(A_SCLR, 32'h20);
        chk("R10 irq after clear", 32'(irq_out), 0);
        wr(A_IEN, 0);
        @(negedge clk);
        pin_in = '0;
        wait_clk(3);
    endtask

    task automatic t_disabled;
        wr(A_MODE0, 32'h0100_0000);
        @(negedge clk);
        pin_in = 12'h040;
        wait_clk(4);
        rdchk("R9 disabled no status", A_STAT, 0);
        chk("R9 disabled no irq", 32'(irq_out), 0);
        wr(A_IEN, 32'h40);
        wait_clk(2);
        rdchk("R9 late enable no event", A_STAT, 0);
        wr(A_IEN, 0);
        @(negedge clk);
        pin_in = '0;
        wait_clk(3);
    endtask

    task automatic t_srst;
        wr(A_DOUT, 32'hABC);
        wr(A_DIR, 32'hF0F);
        wr(A_IEN, 32'h1);
        wr(A_MSET, 32'h3);
        wr(A_MODE0, 32'h3);
        wr(A_SRST, 1);
        wait_clk(1);
        rdchk("R11 srst reads held", A_SRST, 1);
        rdchk("R11 dout held zero", A_DOUT, 0);
        wr(A_DOUT, 32'h55);
        rdchk("R11 write ignored", A_DOUT, 0);
        wr(A_SRST, 0);
        rdchk("R11 srst released", A_SRST, 0);
        rdchk("R11 dir", A_DIR, 0);
        rdchk("R11 ien", A_IEN, 0);
        rdchk("R11 mask", A_MSET, 0);
        rdchk("R11 mode0", A_MODE0, 0);
        chk("R11 oe", 32'(pin_oe), 0);
        wr(A_DOUT, 32'h55);
        rdchk("R11 writes resume", A_DOUT, 32'h55);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_output();
        t_input();
        t_modes();
        t_edge();
        t_level();
        t_mask();
        t_disabled();
        t_srst();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule